// File: doc/BRIEF.md
# Interrupt Status and DMA Request Unit

This unit keeps the event flags of a serial bus controller, an interrupt enable mask and a pair of DMA enables. Other logic raises flags with one-cycle set pulses. The unit drives one combined interrupt line and two DMA request lines: a receive request that follows the receive-ready flag and a transmit request that follows the transmit-ready flag. The serial engine and the data buffer are outside the unit.

Software uses a small word-addressed register port. Read data appears on `reg_rdata` one clock after the read strobe. A static `rev_new` input selects one of two variants. In the older variant (`rev_new`=0) software drains interrupts through a vector register. Each read of that register returns the one-based index of the lowest enabled pending flag and clears that flag. In the newer variant (`rev_new`=1) software clears flags by writing ones to the status register, and the vector register reads as zero.

Register selects on `reg_addr`: 0 enable mask, 1 status, 2 vector, 3 DMA enables, 4 self-test. Flag positions: bit 3 is receive ready, bit 4 is transmit ready, bit 12 is the live bus-busy view.

Top module: `irq_dma_status_unit`

## Requirements
- R1: `irq` is high exactly when some status bit in positions 0..5 and the matching enable-mask bit are both set.
- R2: `dma_rx_req` equals the receive DMA enable AND status bit 3. `dma_tx_req` equals the transmit DMA enable AND status bit 4.
- R3: A write to select 3 keeps only data bits 15 (receive enable) and 7 (transmit enable), and it reads back with the same positions. Writing bit 15 as 1 clears enable-mask bit 3. Writing bit 7 as 1 clears enable-mask bit 4.
- R4: With `rev_new`=0, a read of select 2 returns the value (lowest set position of status AND mask)+1, or 0 when nothing is pending. The same read clears that status bit.
- R5: With `rev_new`=1, a read of select 2 returns 0 and leaves the status unchanged.
- R6: With `rev_new`=1, a write to select 1 clears the status bits where the data AND 0x27 has a one. Bits 3 and 4 are never cleared this way.
- R7: With `rev_new`=0, a write to select 1 leaves the status unchanged.
- R8: A write to select 0 stores data AND 0x1f when `rev_new`=0, and data AND 0x3f when `rev_new`=1.
- R9: A read of select 1 shows `bus_busy` in bit 12 as sampled in the read cycle. Bit 12 is never stored: `set_in[12]` has no effect.
- R10: With `rev_new`=1, a write to select 4 with data bit 11 set raises status bits 0..5. With `rev_new`=0 the same write changes nothing.
- R11: When a set pulse and a clear (by write-one or by vector read) target the same bit in the same cycle, the bit ends up set.
- R12: A synchronous reset clears the mask, the status and both DMA enables. It drives `irq`, `dma_rx_req`, `dma_tx_req` and `reg_rdata` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rev_new | input | 1 | 1 selects the write-to-clear variant, 0 selects the vector variant |
| bus_busy | input | 1 | Live bus-busy indication, shown in status bit 12 |
| set_in | input | 16 | One-cycle set pulses, one per status bit |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered one cycle after `reg_rd` |
| irq | output | 1 | Combined interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The properties assume that a read strobe and a write strobe are never high in the same cycle. They also assume that `rev_new` does not change on the cycle of an access. The stability checks for the vector read and the status write apply only in cycles with no set pulse, so flags raised by other logic are not counted as errors. The directed bench issues one register access at a time and changes `rev_new` only while the port is idle. It combines a set pulse with a clear only in the scenario that tests which one wins.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;
   typedef enum logic [2:0] {
      REG_MASK = 3'd0,
      REG_STAT = 3'd1,
      REG_VEC  = 3'd2,
      REG_DMA  = 3'd3,
      REG_TEST = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/irq_stat_bank.sv
// Status flag storage: set pulses take priority over clears.
module irq_stat_bank #(
   parameter int               W    = 16,
   parameter logic [W-1:0]     KEEP = '1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] stat_q
);
   always_ff @(posedge clk) begin
      if (rst) stat_q <= '0;
      else     stat_q <= ((stat_q & ~clr_vec) | set_vec) & KEEP;
   end
endmodule

// File: rtl/irq_lowest_enc.sv
// Finds the lowest set bit; index is one-based, zero when empty.
module irq_lowest_enc #(
   parameter int N     = 6,
   parameter int IDX_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     pend,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);
   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            idx       = IDX_W'(i + 1);
            onehot    = '0;
            onehot[i] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/irq_req_gate.sv
// Per-channel request gating: request = enable AND ready flag.
module irq_req_gate #(
   parameter int N = 2
) (
   input  logic [N-1:0] en,
   input  logic [N-1:0] ready,
   output logic [N-1:0] req
);
   for (genvar g = 0; g < N; g++) begin : g_ch
      assign req[g] = en[g] & ready[g];
   end
endmodule

// File: rtl/irq_dma_status_unit.sv
module irq_dma_status_unit #(
   parameter int            DATA_W     = 16,
   parameter int            IE_W_OLD   = 5,
   parameter int            IE_W_NEW   = 6,
   parameter int            RX_BIT     = 3,
   parameter int            TX_BIT     = 4,
   parameter int            BUSY_BIT   = 12,
   parameter int            TEST_BIT   = 11,
   parameter int            TEST_SET_W = 6,
   parameter int            RX_EN_BIT  = 15,
   parameter int            TX_EN_BIT  = 7,
   parameter logic [15:0]   W1C_MASK   = 16'h0027
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rev_new,
   input  logic              bus_busy,
   input  logic [DATA_W-1:0] set_in,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              dma_rx_req,
   output logic              dma_tx_req
);
   import irq_dma_pkg::*;

   localparam int                 MASK_W  = IE_W_NEW;
   localparam int                 IDX_W   = $clog2(MASK_W + 1);
   localparam logic [MASK_W-1:0]  LIM_OLD = MASK_W'((1 << IE_W_OLD) - 1);
   localparam logic [MASK_W-1:0]  LIM_NEW = MASK_W'((1 << IE_W_NEW) - 1);
   localparam logic [DATA_W-1:0]  KEEP    = ~(DATA_W'(1) << BUSY_BIT);
   localparam logic [DATA_W-1:0]  TEST_SET = DATA_W'((1 << TEST_SET_W) - 1);
   localparam logic [DATA_W-1:0]  W1C     = DATA_W'(W1C_MASK);

   if (DATA_W <= RX_EN_BIT || DATA_W <= BUSY_BIT || DATA_W <= TEST_BIT) begin : g_bad_dw
      $error("DATA_W too narrow for the bit positions in use");
   end
   if (IE_W_OLD > IE_W_NEW || RX_BIT >= MASK_W || TX_BIT >= MASK_W) begin : g_bad_ie
      $error("enable widths or ready positions inconsistent");
   end
   if (TEST_SET_W > MASK_W) begin : g_bad_test
      $error("self-test field wider than the mask");
   end

   logic [DATA_W-1:0] stat_q;
   logic [MASK_W-1:0] mask_q;
   logic              rx_en_q, tx_en_q;
   logic [MASK_W-1:0] pend;
   logic [IDX_W-1:0]  vec_idx;
   logic [MASK_W-1:0] vec_onehot;
   logic [DATA_W-1:0] set_vec, clr_vec, rd_mux;
   logic              wr_mask, wr_stat, wr_dma, wr_test, rd_vec;

   assign wr_mask = reg_wr && (reg_addr == REG_MASK);
   assign wr_stat = reg_wr && (reg_addr == REG_STAT);
   assign wr_dma  = reg_wr && (reg_addr == REG_DMA);
   assign wr_test = reg_wr && (reg_addr == REG_TEST);
   assign rd_vec  = reg_rd && (reg_addr == REG_VEC);

   assign pend = stat_q[MASK_W-1:0] & mask_q;

   irq_lowest_enc #(.N(MASK_W), .IDX_W(IDX_W)) u_enc (
      .pend   (pend),
      .idx    (vec_idx),
      .onehot (vec_onehot)
   );

   always_comb begin
      clr_vec = '0;
      if (rd_vec && !rev_new)  clr_vec = clr_vec | DATA_W'(vec_onehot);
      if (wr_stat && rev_new)  clr_vec = clr_vec | (reg_wdata & W1C);
      set_vec = set_in;
      if (wr_test && rev_new && reg_wdata[TEST_BIT]) set_vec = set_vec | TEST_SET;
   end

   irq_stat_bank #(.W(DATA_W), .KEEP(KEEP)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .stat_q  (stat_q)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         mask_q  <= '0;
         rx_en_q <= 1'b0;
         tx_en_q <= 1'b0;
      end else if (wr_mask) begin
         mask_q <= reg_wdata[MASK_W-1:0] & (rev_new ? LIM_NEW : LIM_OLD);
      end else if (wr_dma) begin
         rx_en_q <= reg_wdata[RX_EN_BIT];
         tx_en_q <= reg_wdata[TX_EN_BIT];
         if (reg_wdata[RX_EN_BIT]) mask_q[RX_BIT] <= 1'b0;
         if (reg_wdata[TX_EN_BIT]) mask_q[TX_BIT] <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         REG_MASK: rd_mux = DATA_W'(mask_q);
         REG_STAT: rd_mux = stat_q | (DATA_W'(bus_busy) << BUSY_BIT);
         REG_VEC:  rd_mux = rev_new ? '0 : DATA_W'(vec_idx);
         REG_DMA:  rd_mux = (DATA_W'(rx_en_q) << RX_EN_BIT) | (DATA_W'(tx_en_q) << TX_EN_BIT);
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)         reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   assign irq = |pend;

   irq_req_gate #(.N(2)) u_gate (
      .en    ({tx_en_q, rx_en_q}),
      .ready ({stat_q[TX_BIT], stat_q[RX_BIT]}),
      .req   ({dma_tx_req, dma_rx_req})
   );
endmodule

// File: rtl/irq_dma_status_unit_chk.sv
module irq_dma_status_unit_chk #(
   parameter int DATA_W = 16,
   parameter int MASK_W = 6
) (
   input logic              clk,
   input logic              rst,
   input logic              rev_new,
   input logic [DATA_W-1:0] set_in,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [2:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              dma_rx_req,
   input logic              dma_tx_req,
   input logic [DATA_W-1:0] stat_q,
   input logic [MASK_W-1:0] mask_q
);
   import irq_dma_pkg::*;

   logic [MASK_W-1:0] pend_c, low_c;
   assign pend_c = stat_q[MASK_W-1:0] & mask_q;
   assign low_c  = pend_c & (~pend_c + MASK_W'(1));

   assert_rx_off_R2: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == REG_DMA && !reg_wdata[15]) |=> !dma_rx_req);
   assert_tx_off_R2: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == REG_DMA && !reg_wdata[7]) |=> !dma_tx_req);
   assert_unmask_rx_R3: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == REG_DMA && reg_wdata[15]) |=> !mask_q[3]);
   assert_unmask_tx_R3: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == REG_DMA && reg_wdata[7]) |=> !mask_q[4]);
   assert_vec_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (reg_rd && !reg_wr && reg_addr == REG_VEC && !rev_new && pend_c != '0)
      |=> ((stat_q[MASK_W-1:0] & $past(low_c & ~set_in[MASK_W-1:0])) == '0));
   assert_vec_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (reg_rd && !reg_wr && reg_addr == REG_VEC && rev_new && set_in == '0)
      |=> ($stable(stat_q) && reg_rdata == '0));
   assert_stat_ro_R7: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && !reg_rd && reg_addr == REG_STAT && !rev_new && set_in == '0)
      |=> $stable(stat_q));
   assert_mask_bound_R8: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_addr == REG_MASK && !rev_new) |=> (mask_q[MASK_W-1:5] == '0));
   assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
      (set_in != '0) |=> (($past(set_in) & ~(DATA_W'(1) << 12) & ~stat_q) == '0));
endmodule

bind irq_dma_status_unit irq_dma_status_unit_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .rev_new    (rev_new),
   .set_in     (set_in),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .reg_rdata  (reg_rdata),
   .dma_rx_req (dma_rx_req),
   .dma_tx_req (dma_tx_req),
   .stat_q     (stat_q),
   .mask_q     (mask_q)
);

// File: tb/irq_dma_status_unit_tb.sv
module irq_dma_status_unit_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rev_new = 1'b0;
   logic        bus_busy = 1'b0;
   logic [15:0] set_in = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq, dma_rx_req, dma_tx_req;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   irq_dma_status_unit u_dut (
      .clk(clk), .rst(rst), .rev_new(rev_new), .bus_busy(bus_busy), .set_in(set_in),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk) begin reg_wr = 1'b1; reg_addr = a; reg_wdata = d; end
      @(negedge clk) reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk) begin reg_rd = 1'b1; reg_addr = a; end
      @(negedge clk) reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [15:0] b);
      @(negedge clk) set_in = b;
      @(negedge clk) set_in = '0;
   endtask

   task automatic t_reset_R12();
      logic [15:0] d;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R12 outputs", {13'd0, irq, dma_rx_req, dma_tx_req}, 16'h0);
      chk("R12 rdata", reg_rdata, 16'h0);
      rst = 1'b0;
      rd(3'd1, d); chk("R12 status", d, 16'h0);
      rd(3'd0, d); chk("R12 mask", d, 16'h0);
      rd(3'd3, d); chk("R12 dma", d, 16'h0);
   endtask

   task automatic t_mask_R8_R1();
      logic [15:0] d;
      do_reset(); rev_new = 1'b0;
      wr(3'd0, 16'hffff); rd(3'd0, d); chk("R8 old mask", d, 16'h001f);
      rev_new = 1'b1;
      wr(3'd0, 16'hffff); rd(3'd0, d); chk("R8 new mask", d, 16'h003f);
      chk("R1 idle irq", {15'd0, irq}, 16'h0);
      pulse(16'h0004); chk("R1 irq set", {15'd0, irq}, 16'h1);
      wr(3'd0, 16'h0000); chk("R1 irq masked", {15'd0, irq}, 16'h0);
   endtask

   task automatic t_dma_R2_R3();
      logic [15:0] d;
      do_reset(); rev_new = 1'b1;
      wr(3'd0, 16'h003f);
      wr(3'd3, 16'hffff); rd(3'd3, d); chk("R3 dma readback", d, 16'h8080);
      rd(3'd0, d); chk("R3 mask bits cleared", d, 16'h0027);
      pulse(16'h0008);
      chk("R2 rx req", {14'd0, dma_rx_req, dma_tx_req}, 16'h2);
      pulse(16'h0010);
      chk("R2 both req", {14'd0, dma_rx_req, dma_tx_req}, 16'h3);
      wr(3'd3, 16'h0080);
      chk("R2 rx disabled", {14'd0, dma_rx_req, dma_tx_req}, 16'h1);
      rd(3'd0, d); chk("R3 mask after tx only", d, 16'h0027);
   endtask

   task automatic t_vector_R4();
      logic [15:0] d;
      do_reset(); rev_new = 1'b0;
      wr(3'd0, 16'h001f);
      pulse(16'h0012);
      rd(3'd2, d); chk("R4 first vector", d, 16'h0002);
      rd(3'd1, d); chk("R4 bit1 cleared", d, 16'h0010);
      rd(3'd2, d); chk("R4 second vector", d, 16'h0005);
      rd(3'd2, d); chk("R4 empty vector", d, 16'h0000);
      chk("R4 irq dropped", {15'd0, irq}, 16'h0);
   endtask

   task automatic t_vector_new_R5();
      logic [15:0] d;
      do_reset(); rev_new = 1'b1;
      wr(3'd0, 16'h003f);
      pulse(16'h0012);
      rd(3'd2, d); chk("R5 vector zero", d, 16'h0000);
      rd(3'd1, d); chk("R5 status kept", d, 16'h0012);
   endtask

   task automatic t_w1c_R6_R7();
      logic [15:0] d;
      do_reset(); rev_new = 1'b1;
      pulse(16'h003f);
      wr(3'd1, 16'hffff); rd(3'd1, d); chk("R6 write-one clear", d, 16'h0018);
      do_reset(); rev_new = 1'b0;
      pulse(16'h003f);
      wr(3'd1, 16'hffff); rd(3'd1, d); chk("R7 read-only status", d, 16'h003f);
   endtask

   task automatic t_busy_R9();
      logic [15:0] d;
      do_reset(); rev_new = 1'b1;
      pulse(16'h1000);
      bus_busy = 1'b1; rd(3'd1, d); chk("R9 busy shown", d, 16'h1000);
      bus_busy = 1'b0; rd(3'd1, d); chk("R9 busy not stored", d, 16'h0000);
   endtask

   task automatic t_selftest_R10();
      logic [15:0] d;
      do_reset(); rev_new = 1'b1;
      wr(3'd4, 16'h0800); rd(3'd1, d); chk("R10 new forces flags", d, 16'h003f);
      do_reset(); rev_new = 1'b0;
      wr(3'd4, 16'h0800); rd(3'd1, d); chk("R10 old no effect", d, 16'h0000);
   endtask

   task automatic t_set_wins_R11();
      logic [15:0] d;
      do_reset(); rev_new = 1'b1;
      @(negedge clk) begin set_in = 16'h0001; reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 16'h0001; end
      @(negedge clk) begin set_in = '0; reg_wr = 1'b0; end
      rd(3'd1, d); chk("R11 set beats write clear", d, 16'h0001);
      do_reset(); rev_new = 1'b0;
      wr(3'd0, 16'h001f);
      pulse(16'h0002);
      @(negedge clk) begin set_in = 16'h0002; reg_rd = 1'b1; reg_addr = 3'd2; end
      @(negedge clk) begin set_in = '0; reg_rd = 1'b0; end
      chk("R11 vector value", reg_rdata, 16'h0002);
      rd(3'd1, d); chk("R11 set beats vector clear", d, 16'h0002);
   endtask

   initial begin
      #(200000 * 20);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset_R12();
      t_mask_R8_R1();
      t_dma_R2_R3();
      t_vector_R4();
      t_vector_new_R5();
      t_w1c_R6_R7();
      t_busy_R9();
      t_selftest_R10();
      t_set_wins_R11();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule